// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM of 1M words by 4 bits. The host hands over one word at a time through a valid/ready request port that carries a 20-bit address, a write flag and 4 bits of write data. The controller turns each request into a timed sequence of active-low chip select, write enable and output enable, and it steers a shared 4-bit data bus. Read results come back on a data output with a one-cycle valid strobe.

Every phase length is a parameter counted in clock cycles. Each length is the ceiling of a nanosecond limit divided by the clock period, and it is never less than one cycle. A write runs through three phases: address setup, write pulse and write recovery. A read runs through an access phase, then a bus turnaround phase. Between requests chip select stays high, so the memory sits in its low-power standby state. The controller drives the data lines only while output enable is high, and only after the memory has had time to release the bus.

The pad-level tristate is outside this block. The controller exposes its own drive value, a drive enable, and the sampled bus value.

Top module: `sram_seq_ctrl`

## Requirements
- R1: During reset and right after it: `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `in_ready` is 1 and `rd_valid` is 0.
- R2: A write keeps chip select low and the address unchanged for N_ASU+N_WP+N_WR cycles. Write enable goes low only after N_ASU cycles of address setup and stays low for exactly N_WP cycles.
- R3: `mem_dq_oe` is 1 only during the write pulse and write recovery. During that time `mem_oe_n` stays 1 and chip select stays low, so the bus is never driven from both ends.
- R4: A read holds chip select and output enable low, with write enable high, for exactly N_RD cycles. The bus value sampled on the last of those cycles appears on `rd_data`, and `rd_valid` is 1 for exactly one cycle in the clock that follows.
- R5: After a read, chip select and output enable stay high for N_TA turnaround cycles. `mem_dq_oe` never rises before output enable has been high for at least N_TA cycles.
- R6: `in_ready` falls in the cycle after a request is accepted. With the default parameters it stays low for exactly 5 cycles, both for a write (1+3+1) and for a read (3+2). A new request is accepted in the first cycle in which `in_ready` is 1 again.
- R7: While `in_ready` is 1 and `in_valid` is 0, the request inputs have no effect: chip select stays high (standby) and the bus is not driven.
- R8: Each phase length is ceil(ns / CLK_NS), with a minimum of 1. The write pulse is also long enough to cover the data setup time and the address-to-write-high time, and recovery is long enough to cover the full write cycle. With the defaults (4 ns clock): N_ASU=1, N_WP=3, N_WR=1, N_RD=3, N_TA=2.
- R9: Write enable is low only while chip select is low.
- R10: Data written to an address is returned by later reads of that address, including the boundary addresses 0x00000 and 0xFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Controller idle and able to accept a request |
| in_write | input | 1 | 1 = write request, 0 = read request |
| in_addr | input | 20 | Word address |
| in_wdata | input | 4 | Write data |
| rd_valid | output | 1 | One-cycle strobe marking `rd_data` valid |
| rd_data | output | 4 | Read result |
| mem_addr | output | 20 | Address to memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_o | output | 4 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Enable for the controller's bus driver |
| mem_dq_i | input | 4 | Sampled data bus value |

## Verification
The embedded assertions check the following on every cycle:
- write enable is low only inside chip select;
- the controller's driver is enabled only while output enable is high;
- the address is stable while chip select is low;
- the write pulse width and the turnaround gap, measured with counters;
- the drop of ready after acceptance, the single-cycle read strobe, and the idle standby state.

Only the bench's scenarios can show the rest. A behavioural memory model measures the phase lengths it sees and flags any bus contention. The bench checks the busy length of every transfer and the back-to-back acceptance. It also checks that written data reads back correctly through the boundary addresses and through random mixed traffic.

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl #(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 4,
  parameter int CLK_NS    = 4,
  parameter int T_ASU_NS  = 0,
  parameter int T_WP_NS   = 10,
  parameter int T_DSU_NS  = 6,
  parameter int T_AWH_NS  = 10,
  parameter int T_WR_NS   = 1,
  parameter int T_WC_NS   = 12,
  parameter int T_RD_NS   = 12,
  parameter int T_TA_NS   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_write,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int N_ASU = cyc(T_ASU_NS);
  localparam int N_WP  = mx(mx(cyc(T_WP_NS), cyc(T_DSU_NS)), cyc(T_AWH_NS) - N_ASU);
  localparam int N_WR  = mx(cyc(T_WR_NS), cyc(T_WC_NS) - N_ASU - N_WP);
  localparam int N_RD  = cyc(T_RD_NS);
  localparam int N_TA  = cyc(T_TA_NS);
  localparam int N_MAX = mx(mx(mx(N_ASU, N_WP), mx(N_WR, N_RD)), N_TA);
  localparam int CNT_W = $clog2(N_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_PULSE, S_RECOV, S_ACCESS, S_TURN} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt, len_m1;
  logic [ADDR_W-1:0] a_q;
  logic [DATA_W-1:0] d_q;
  logic              last;

  always_comb begin
    case (st)
      S_SETUP:  len_m1 = CNT_W'(N_ASU - 1);
      S_PULSE:  len_m1 = CNT_W'(N_WP - 1);
      S_RECOV:  len_m1 = CNT_W'(N_WR - 1);
      S_ACCESS: len_m1 = CNT_W'(N_RD - 1);
      S_TURN:   len_m1 = CNT_W'(N_TA - 1);
      default:  len_m1 = '0;
    endcase
  end

  assign last = (cnt == len_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      a_q      <= '0;
      d_q      <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      cnt      <= last ? '0 : cnt + 1'b1;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (in_valid) begin
            a_q <= in_addr;
            d_q <= in_wdata;
            st  <= in_write ? S_SETUP : S_ACCESS;
          end
        end
        S_SETUP: if (last) st <= S_PULSE;
        S_PULSE: if (last) st <= S_RECOV;
        S_RECOV: if (last) st <= S_IDLE;
        S_ACCESS: if (last) begin
          rd_data  <= mem_dq_i;
          rd_valid <= 1'b1;
          st       <= S_TURN;
        end
        S_TURN: if (last) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign in_ready  = (st == S_IDLE);
  assign mem_addr  = a_q;
  assign mem_dq_o  = d_q;
  assign mem_cs_n  = !(st == S_SETUP || st == S_PULSE || st == S_RECOV || st == S_ACCESS);
  assign mem_we_n  = (st != S_PULSE);
  assign mem_oe_n  = (st != S_ACCESS);
  assign mem_dq_oe = (st == S_PULSE || st == S_RECOV);

  logic [CNT_W-1:0] we_lo_cnt, oe_hi_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_lo_cnt <= '0;
      oe_hi_cnt <= CNT_W'(N_MAX);
    end else begin
      we_lo_cnt <= mem_we_n ? '0 : ((we_lo_cnt < CNT_W'(N_MAX)) ? we_lo_cnt + 1'b1 : we_lo_cnt);
      oe_hi_cnt <= !mem_oe_n ? '0 : ((oe_hi_cnt < CNT_W'(N_MAX)) ? oe_hi_cnt + 1'b1 : oe_hi_cnt);
    end
  end

  // R9
  we_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |-> !mem_cs_n);
  // R3
  drive_safe_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_dq_oe |-> (mem_oe_n && !mem_cs_n));
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
  // R2
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo_cnt == CNT_W'(N_WP)));
  // R5
  turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_hi_cnt >= CNT_W'(N_TA)));
  // R6
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready) |=> !in_ready);
  // R4
  rdv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |=> !rd_valid);
  // R7
  idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> (mem_cs_n && !mem_dq_oe));

endmodule

// File: tb/test_sram_seq_ctrl.sv
module test_sram_seq_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0, in_write = 0;
  logic [19:0] in_addr = '0;
  logic [3:0]  in_wdata = '0;
  logic        in_ready, rd_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [3:0]  rd_data, mem_dq_o;
  logic [3:0]  mem_dq_i = '0;
  logic [19:0] mem_addr;

  sram_seq_ctrl i_sram_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_write(in_write), .in_addr(in_addr), .in_wdata(in_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i));

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [3:0] mem_m [int];
  logic [3:0] ref_m [int];
  logic [3:0] exp_q [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      chk(0, "watchdog", cyc, 100000);
      report();
    end
  end

  // memory model and monitor
  bit prev_we = 1, prev_oe = 1, prev_rv = 0, prev_dq = 0;
  int we_run = 0, oe_run = 0, oe_hi = 100;
  int cont_err = 0, ovl_err = 0, dsu_err = 0;
  always @(negedge clk) if (rst_n) begin
    if (!mem_we_n && mem_cs_n) ovl_err++;
    if (mem_dq_oe && !mem_cs_n && mem_we_n && !mem_oe_n) cont_err++;
    if (!mem_we_n) begin
      we_run++;
      if (!mem_dq_oe) dsu_err++;
    end
    if (mem_we_n && !prev_we) begin
      chk(we_run == 3, "R2 R8 write pulse cycles", we_run, 3);
      chk(mem_dq_oe == 1, "R3 data hold after write strobe", mem_dq_oe, 1);
      mem_m[int'(mem_addr)] = mem_dq_o;
      we_run = 0;
    end
    if (!mem_oe_n) oe_run++;
    if (mem_oe_n && !prev_oe) begin
      chk(oe_run == 3, "R4 R8 read access cycles", oe_run, 3);
      oe_run = 0;
    end
    if (mem_dq_oe && !prev_dq) chk(oe_hi >= 2, "R5 turnaround before drive", oe_hi, 2);
    oe_hi = mem_oe_n ? oe_hi + 1 : 0;
    if (rd_valid) begin
      chk(!prev_rv, "R4 single cycle valid", prev_rv, 0);
      if (exp_q.size() == 0) chk(0, "R4 unexpected read data", 1, 0);
      else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R10 read data", rd_data, e);
      end
    end
    mem_dq_i = (!mem_cs_n && mem_we_n && !mem_oe_n)
             ? (mem_m.exists(int'(mem_addr)) ? mem_m[int'(mem_addr)] : 4'h0) : 4'h0;
    prev_we = mem_we_n; prev_oe = mem_oe_n; prev_rv = rd_valid; prev_dq = mem_dq_oe;
  end

  task automatic req(input bit w, input logic [19:0] a, input logic [3:0] d);
    int busy;
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_write = w; in_addr = a; in_wdata = d;
    if (w) ref_m[int'(a)] = d;
    else exp_q.push_back(ref_m.exists(int'(a)) ? ref_m[int'(a)] : 4'h0);
    @(negedge clk);
    in_valid = 0;
    in_addr = $urandom; in_wdata = $urandom;
    busy = 0;
    while (!in_ready) begin
      busy++;
      @(negedge clk);
    end
    chk(busy == 5, "R6 busy cycles", busy, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_cs_n && mem_we_n && mem_oe_n, "R1 controls idle in reset", {mem_cs_n, mem_we_n, mem_oe_n}, 7);
    chk(!mem_dq_oe && in_ready && !rd_valid, "R1 drive/ready/valid in reset", {mem_dq_oe, in_ready, rd_valid}, 2);
    rst_n = 1;
    @(negedge clk);
    chk(mem_cs_n && in_ready && !mem_dq_oe, "R1 idle after reset", {mem_cs_n, in_ready, mem_dq_oe}, 6);

    // R7: inputs ignored without valid
    for (int i = 0; i < 8; i++) begin
      in_write = $urandom; in_addr = $urandom; in_wdata = $urandom;
      @(negedge clk);
      chk(mem_cs_n && in_ready && !mem_dq_oe && !rd_valid, "R7 standby while no request",
          {mem_cs_n, in_ready, mem_dq_oe, rd_valid}, 12);
    end
    in_write = 0;
    req(0, 20'h00123, 0);

    req(1, 20'h00000, 4'hA);
    req(1, 20'hFFFFF, 4'h5);
    req(0, 20'h00000, 0);
    req(0, 20'hFFFFF, 0);
    req(1, 20'h00000, 4'h3);
    req(0, 20'h00000, 0);
    // R5: read followed at once by a write
    req(0, 20'hFFFFF, 0);
    req(1, 20'h00010, 4'hF);
    req(0, 20'h00010, 0);

    for (int i = 0; i < 300; i++)
      req($urandom_range(0, 1), 20'($urandom_range(0, 47)), 4'($urandom));
    for (int i = 0; i < 48; i++) req(0, 20'(i), 0);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all reads returned", exp_q.size(), 0);
    chk(cont_err == 0, "R3 bus contention", cont_err, 0);
    chk(dsu_err == 0, "R3 data driven during pulse", dsu_err, 0);
    chk(ovl_err == 0, "R9 write strobe outside select", ovl_err, 0);
    report();
  end
endmodule